// File: doc/BRIEF.md
# Sampled-Insertion Filtered Cache Controller

This block is the tag and control path of a first-level cache built from two parts: a direct-mapped main array and a small fully-associative side buffer, called the filter. Each access first looks in the main array and then in the filter. If the line is in neither, the block sends one line-aligned request to the next memory level through a valid/ready handshake and waits for the response strobe. Only one miss is outstanding at a time, and new accesses are held off until its refill is done. The model holds only tags and valid bits. It has no data arrays, no coherence and no write-back.

A missed line is placed by a sampled decision, not by any reuse history. A counter counts refill decisions, and every Nth one puts the line in the main array, where N is set on the `sample_period` input. Every other refill goes into the filter. The filter replaces by true LRU, and a filter hit is served in place without promotion. Frequently used lines see many refill decisions, so they tend to reach the main array. Lines used for only a short time mostly stay in the filter.

Top module: `filt_cache_ctl`

## Requirements
- R1: A request whose line is valid in the main array, at set index equal to the line address modulo L1_SETS, produces `rsp_valid` with `rsp_l1_hit` one cycle after acceptance. It causes no next-level request.
- R2: A request that misses the main array but matches a valid filter entry produces `rsp_valid` with `rsp_filt_hit` one cycle after acceptance. It causes no next-level request, and the line stays in the filter, so a repeat access is again a filter hit.
- R3: A request that misses both structures raises `mem_req_valid` with `mem_req_addr` equal to the request address with its low log2(LINE_BYTES) bits cleared. The request and its address hold until `mem_req_ready`. `req_ready` stays low until the refill completes. `rsp_valid` with `rsp_miss` follows one cycle after `mem_rsp_valid`.
- R4: Refill decisions are counted from reset. Decision number k·N, for N = `sample_period`, places the line in the main array, and `rsp_to_l1` is 1 with the miss response. All other decisions place it in the filter, with `rsp_to_l1` at 0. A period of 0 acts as 1.
- R5: A refill placed in the main array replaces the line previously held in that set, so that the older line then misses.
- R6: When the filter is full, a refill into it evicts the entry least recently inserted or hit.
- R7: Exactly one of `rsp_l1_hit`, `rsp_filt_hit` and `rsp_miss` is set with each `rsp_valid`, and no line is held in both structures.
- R8: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, both structures are empty and the sampling counter is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_period | input | PER_W | Refill decisions per main-array placement |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_ready | output | 1 | Block can accept an access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_l1_hit | output | 1 | Response was a main-array hit |
| rsp_filt_hit | output | 1 | Response was a filter hit |
| rsp_miss | output | 1 | Response was a refilled miss |
| rsp_to_l1 | output | 1 | Refilled line was placed in the main array |
| mem_req_valid | output | 1 | Next-level request valid |
| mem_req_addr | output | ADDR_W | Line-aligned next-level address |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_rsp_valid | input | 1 | Next level returns the line |

## Verification
The bench pushes the sampling counter past several periods. A placement counter that was off by one, or that did not restart after a main-array placement, would send the wrong refill to the main array. Periods of 0 and 1 are also driven; these must send every refill to the main array. A design that treated 0 as a huge period would keep filling the filter. The filter is filled to capacity and then refreshed by hits before evictions. A victim choice that ignores hit recency, or that is FIFO, would evict a recently used line and turn a later filter hit into a miss. Repeated filter hits, conflict refills in one direct-mapped set, and a slow next-level grant are also exercised. These would expose a design that promotes filter lines, keeps stale main-array tags, or drops or alters its request before the grant.

// File: rtl/filt_cache_ctl.sv
module filt_cache_ctl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int L1_SETS    = 256,
  parameter int FILT_LINES = 32,
  parameter int PER_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  sample_period,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_l1_hit,
  output logic              rsp_filt_hit,
  output logic              rsp_miss,
  output logic              rsp_to_l1,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(L1_SETS);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LA_W - IDX_W;
  localparam int AGE_W = $clog2(FILT_LINES);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  logic [TAG_W-1:0]   l1_tag [L1_SETS];
  logic [L1_SETS-1:0] l1_vld;
  logic [LA_W-1:0]    filt_la  [FILT_LINES];
  logic [AGE_W-1:0]   filt_age [FILT_LINES];
  logic [FILT_LINES-1:0] filt_vld;
  logic [LA_W-1:0]    miss_la;
  logic [PER_W-1:0]   cnt;

  logic [LA_W-1:0]  req_la;
  logic [IDX_W-1:0] req_idx, miss_idx;
  logic [TAG_W-1:0] req_tag, miss_tag;
  logic             l1_hit, filt_hit, to_l1, touch_en, accept;
  logic [FILT_LINES-1:0] filt_match;
  logic [AGE_W-1:0] hit_way, victim, touch_way;
  logic [PER_W:0]   cnt_nxt, per_eff;

  assign req_la   = LA_W'(req_addr >> OFF_W);
  assign req_idx  = req_la[IDX_W-1:0];
  assign req_tag  = req_la[LA_W-1:IDX_W];
  assign miss_idx = miss_la[IDX_W-1:0];
  assign miss_tag = miss_la[LA_W-1:IDX_W];
  assign l1_hit   = l1_vld[req_idx] && (l1_tag[req_idx] == req_tag);

  genvar g;
  generate
    for (g = 0; g < FILT_LINES; g++) begin : g_cmp
      assign filt_match[g] = filt_vld[g] && (filt_la[g] == req_la);
    end
  endgenerate
  assign filt_hit = |filt_match;

  always_comb begin
    hit_way = '0;
    victim  = '0;
    for (int i = 0; i < FILT_LINES; i++) begin
      if (filt_match[i]) hit_way = AGE_W'(i);
      if (filt_age[i] == AGE_W'(FILT_LINES - 1)) victim = AGE_W'(i);
    end
  end

  assign cnt_nxt = {1'b0, cnt} + (PER_W+1)'(1);
  assign per_eff = (sample_period == '0) ? (PER_W+1)'(1) : {1'b0, sample_period};
  assign to_l1   = cnt_nxt >= per_eff;

  assign req_ready     = (state == S_IDLE);
  assign accept        = req_ready && req_valid;
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr  = {miss_la, {OFF_W{1'b0}}};

  assign touch_en  = (accept && !l1_hit && filt_hit) ||
                     (state == S_WAIT && mem_rsp_valid && !to_l1);
  assign touch_way = (state == S_IDLE) ? hit_way : victim;

  always_ff @(posedge clk) begin
    if (state == S_WAIT && mem_rsp_valid) begin
      if (to_l1) l1_tag[miss_idx] <= miss_tag;
      else       filt_la[victim]  <= miss_la;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      l1_vld       <= '0;
      filt_vld     <= '0;
      miss_la      <= '0;
      rsp_valid    <= 1'b0;
      rsp_l1_hit   <= 1'b0;
      rsp_filt_hit <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_to_l1    <= 1'b0;
      for (int i = 0; i < FILT_LINES; i++) filt_age[i] <= AGE_W'(i);
    end else begin
      rsp_valid    <= 1'b0;
      rsp_l1_hit   <= 1'b0;
      rsp_filt_hit <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_to_l1    <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          rsp_valid    <= l1_hit || filt_hit;
          rsp_l1_hit   <= l1_hit;
          rsp_filt_hit <= !l1_hit && filt_hit;
          if (!l1_hit && !filt_hit) begin
            miss_la <= req_la;
            state   <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_miss  <= 1'b1;
          rsp_to_l1 <= to_l1;
          cnt       <= to_l1 ? '0 : cnt_nxt[PER_W-1:0];
          if (to_l1) l1_vld[miss_idx] <= 1'b1;
          else       filt_vld[victim] <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      for (int i = 0; i < FILT_LINES; i++) begin
        if (touch_en) begin
          if (AGE_W'(i) == touch_way) filt_age[i] <= '0;
          else if (filt_age[i] < filt_age[touch_way]) filt_age[i] <= filt_age[i] + 1'b1;
        end
      end
    end
  end

  assert_one_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_l1_hit, rsp_filt_hit, rsp_miss}) == 1);
  assert_no_dual_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !(l1_hit && filt_hit));
  assert_filt_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(filt_match));
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  assert_refill_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && mem_rsp_valid) |=> (rsp_valid && rsp_miss));
  assert_place_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_to_l1 |-> (rsp_valid && rsp_miss));
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < per_eff || $changed(sample_period));
endmodule

// File: tb/test_filt_cache_ctl.sv
module test_filt_cache_ctl;
  localparam int ADDR_W = 32;
  localparam int PER_W  = 12;
  localparam int NV     = 16;
  // codes: 1 main hit, 2 filter hit, 3 miss placed in filter, 4 miss placed in main array
  localparam logic [31:0] VEC_LINE [NV] = '{0, 0, 1, 2, 3, 3, 0, 0, 7, 3, 5, 9, 11, 3, 11, 7};
  localparam logic [2:0]  VEC_EXP  [NV] = '{3, 2, 3, 3, 4, 1, 2, 2, 3, 1, 3, 3, 4, 3, 1, 2};

  logic clk = 0, rst_n = 0;
  logic [PER_W-1:0] sample_period = 4;
  logic req_valid = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_l1_hit, rsp_filt_hit, rsp_miss, rsp_to_l1;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [ADDR_W-1:0] mem_req_addr;

  int n_chk = 0, n_bad = 0, mem_cnt = 0, gnt_dly = 0, rsp_lat = 1;
  logic [ADDR_W-1:0] mem_seen = '0;
  bit done = 0;

  always #2 clk = ~clk;

  filt_cache_ctl #(.ADDR_W(ADDR_W), .LINE_BYTES(64), .L1_SETS(4), .FILT_LINES(16), .PER_W(PER_W))
    i_filt_cache_ctl (.clk, .rst_n, .sample_period, .req_valid, .req_addr, .req_ready,
      .rsp_valid, .rsp_l1_hit, .rsp_filt_hit, .rsp_miss, .rsp_to_l1,
      .mem_req_valid, .mem_req_addr, .mem_req_ready, .mem_rsp_valid);

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 0;
    mem_rsp_valid = 0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (gnt_dly) @(negedge clk);
        mem_seen = mem_req_addr;
        mem_req_ready = 1;
        mem_cnt++;
        @(negedge clk);
        mem_req_ready = 0;
        repeat (rsp_lat) @(negedge clk);
        mem_rsp_valid = 1;
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  task automatic do_reset(input int per);
    rst_n = 0;
    sample_period = PER_W'(per);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic access(input logic [31:0] a, input int exp, input string r);
    int t, r0, code;
    bit stall_seen;
    r0 = mem_cnt;
    stall_seen = 0;
    req_valid = 1;
    req_addr = a;
    t = 0;
    while (!req_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (!rsp_valid && t < 1000) begin
      if (mem_req_valid && !stall_seen) begin
        stall_seen = 1;
        chk(!req_ready, "R3 stall", int'(req_ready), 0);
      end
      @(negedge clk);
      t++;
    end
    chk(t < 1000, "R3 response timeout", t, 0);
    code = rsp_l1_hit ? 1 : rsp_filt_hit ? 2 : (rsp_miss && !rsp_to_l1) ? 3 : (rsp_miss && rsp_to_l1) ? 4 : 0;
    chk(code == exp, r, code, exp);
    chk((mem_cnt - r0) == ((exp >= 3) ? 1 : 0), "R1 R2 next-level request count", mem_cnt - r0, (exp >= 3) ? 1 : 0);
    if (exp >= 3)
      chk(mem_seen == {a[31:6], 6'b0}, "R3 aligned address", int'(mem_seen), int'({a[31:6], 6'b0}));
    chk($countones({rsp_l1_hit, rsp_filt_hit, rsp_miss}) == 1, "R7 one kind", $countones({rsp_l1_hit, rsp_filt_hit, rsp_miss}), 1);
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(4);
    chk(req_ready == 1, "R8 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 0, "R8 no response after reset", int'(rsp_valid), 0);
    chk(mem_req_valid == 0, "R8 no request after reset", int'(mem_req_valid), 0);

    for (int i = 0; i < NV; i++)
      access({VEC_LINE[i][25:0], 6'b0} | 32'((i * 7) & 63), int'(VEC_EXP[i]), "R1 R2 R4 R5 table");

    gnt_dly = 3;
    rsp_lat = 5;
    access({26'd40, 6'd13}, 3, "R3 slow grant miss");
    access({26'd40, 6'd0}, 2, "R2 after slow refill");
    gnt_dly = 0;
    rsp_lat = 1;

    do_reset(100);
    for (int n = 100; n < 116; n++) access({26'(n), 6'd0}, 3, "R6 fill filter");
    access({26'd100, 6'd0}, 2, "R6 refresh oldest");
    access({26'd116, 6'd0}, 3, "R6 evicting miss");
    access({26'd100, 6'd0}, 2, "R6 refreshed line kept");
    access({26'd101, 6'd0}, 3, "R6 LRU line evicted");
    access({26'd103, 6'd0}, 2, "R6 younger line kept");
    access({26'd102, 6'd0}, 3, "R6 next LRU evicted");

    do_reset(0);
    access({26'd0, 6'd0}, 4, "R4 period zero");
    access({26'd0, 6'd5}, 1, "R1 hit after main placement");
    access({26'd4, 6'd0}, 4, "R5 same set conflict");
    access({26'd0, 6'd0}, 4, "R5 replaced line misses");

    do_reset(1);
    access({26'd8, 6'd0}, 4, "R4 period one");
    access({26'd9, 6'd0}, 4, "R4 period one again");

    do_reset(1000);
    access({26'd0, 6'd0}, 3, "R8 empty after reset");
    access({26'd0, 6'd0}, 2, "R2 long period");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule